// File: doc/BRIEF.md
# Multiplexed DRAM-to-SRAM Bus Bridge

This block connects a video controller that was designed for 16K multiplexed-address DRAM to a flat byte-wide static RAM. The controller puts two seven-bit address halves on one shared 8-bit bus, one after the other. It marks them with active-low row and column strobes and an active-low write strobe. The bridge samples these asynchronous strobes on a fast system clock through two-flop synchronizers. It latches each address half a programmable number of clocks after the strobe falls, because the bus can still be settling when the strobe edge arrives. From the two halves it drives a 15-bit SRAM address whose top bit is tied low.

Two controller variants are supported, selected by `mode_split`. In the multiplexed-write variant (`mode_split` = 0), a write cycle places the write byte on the shared bus after the column half, and the bridge holds that byte in its own register. In the split variant (`mode_split` = 1), the read-data bus is bidirectional. The controller drives the write byte on it while its write strobe is low, and the bridge takes the byte from that bus instead of the shared one. In both variants, read data returns on the read-data bus with bit n taken from SRAM data bit n. Bit n of the read-data bus always matches bit n of the shared bus.

Top module: `vram_sram_bridge`

## Requirements
- R1: While `rst_n` is low and after its release with idle strobes, `sram_we_n` and `sram_oe_n` are high and `rd_oe` is low.
- R2: Row bits `ad[7:1]` taken at the row strobe go to `sram_addr[13:7]`, and column bits `ad[7:1]` taken at the column strobe go to `sram_addr[6:0]`. `sram_addr[14]` is always 0.
- R3: Each capture is taken CAPT_DLY (default 2) clocks after the synchronized falling edge. A shared-bus value that changes up to two clocks (10 ns) after `cas_n` falls is still captured correctly.
- R4: When `mode_split` = 0, the write byte is taken from `ad[7:0]` after `rw_n` falls. One or more clocks of `sram_we_n` low then write it to the captured address.
- R5: When `mode_split` = 1, the write byte is taken from `rd_i[7:0]` while `rw_n` is low, and `ad` is used only for address halves.
- R6: In a read cycle, `rd_oe` is high and `rd_o` equals the stored byte no later than 8 clocks after `cas_n` falls, and stays so until `cas_n` rises.
- R7: Bits keep their positions: bit n written through the write path comes back as `rd_o` bit n for every n from 0 to 7. No reordering is done anywhere.
- R8: `rd_oe` is low in every cycle in which `rw_n` is low, in both modes.
- R9: `sram_we_n` and `sram_oe_n` are never low together. While `sram_we_n` stays low, `sram_addr` and `sram_wdata` do not change.
- R10: A read cycle (`rw_n` high throughout) produces no `sram_we_n` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_split | input | 1 | 0: write byte on shared bus, 1: write byte on read-data bus |
| ras_n | input | 1 | Row strobe from controller, active low |
| cas_n | input | 1 | Column strobe from controller, active low |
| rw_n | input | 1 | Write strobe from controller, low means write |
| ad | input | 8 | Shared address/write-data bus |
| rd_i | input | 8 | Read-data bus as driven by the controller (split mode writes) |
| rd_o | output | 8 | Read data returned to the controller |
| rd_oe | output | 1 | Enable for driving `rd_o` onto the read-data bus |
| sram_addr | output | 15 | SRAM address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |

## Verification
In split mode the write strobe and the column strobe can fall on the same clock. The column capture and the write-byte capture then fire together, and the write must still wait for both. The bench provokes this by lowering `rw_n` and driving `rd_i` at the same moment as `cas_n` falls, while the shared bus still shows the row half for two more clocks. It judges the outcome by the address and data seen during the `sram_we_n` pulse and by reading every such location back in a later cycle. It also checks that `rd_oe` never overlaps the controller's own drive.

// File: rtl/vsb_pkg.sv
// Shared constants for the multiplexed DRAM-to-SRAM bridge.
// Assumes an 8-bit shared bus whose top seven bits carry one address half.
package vsb_pkg;
    localparam int DATA_W = 8;
    localparam int HALF_W = DATA_W - 1;
    localparam int NSTRB  = 3;
    // Strobe slot order inside the synchronized vector.
    localparam int S_RAS  = 0;
    localparam int S_CAS  = 1;
    localparam int S_RW   = 2;
    typedef enum logic {
        WMODE_MUXED = 1'b0,
        WMODE_SPLIT = 1'b1
    } wmode_e;
endpackage

// File: rtl/vsb_sync.sv
// Two-flop synchronizer bank for asynchronous active-low strobes.
// Assumes each bit is an independent level; reset value is the idle level.
module vsb_sync #(
    parameter int W = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic st1_q, st2_q;
        // Two stages per bit to settle metastable samples.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st1_q <= RST_VAL;
                st2_q <= RST_VAL;
            end else begin
                st1_q <= d_async[i];
                st2_q <= st1_q;
            end
        end
        assign q_sync[i] = st2_q;
    end
endmodule

// File: rtl/vsb_strobe_timer.sv
// Edge detector and delay counter for one synchronized active-low strobe.
// fire pulses DLY clocks after the detected fall unless the strobe returned
// high first; rise pulses on the detected return. Assumes DLY >= 1.
module vsb_strobe_timer #(
    parameter int DLY = 2,
    localparam int CW = $clog2(DLY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n,
    output logic fire,
    output logic rise
);
    logic          prev_q;
    logic [CW-1:0] cnt_q;
    logic          fall;

    assign fall = prev_q & ~lvl_n;
    assign rise = ~prev_q & lvl_n;
    assign fire = (cnt_q == CW'(1)) & ~lvl_n;

    // Track previous level and count down from the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            prev_q <= lvl_n;
            if (lvl_n)
                cnt_q <= '0;
            else if (fall)
                cnt_q <= CW'(DLY);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/vram_sram_bridge.sv
// Bridge from a multiplexed-address DRAM controller to a flat byte SRAM.
// Rebuilds a 14-bit address from two strobed 7-bit halves, holds the write
// byte from the shared bus or the read-data bus (per mode_split) and drives
// SRAM strobes. Assumes strobes are asynchronous to clk and that each strobe
// stays low well beyond two sync stages plus CAPT_DLY clocks.
module vram_sram_bridge
    import vsb_pkg::*;
#(
    parameter int CAPT_DLY = 2,
    parameter int ADDR_W   = 15,
    localparam int FILL_W  = ADDR_W - 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_split,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              rw_n,
    input  logic [DATA_W-1:0] ad,
    input  logic [DATA_W-1:0] rd_i,
    output logic [DATA_W-1:0] rd_o,
    output logic              rd_oe,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              sram_we_n,
    output logic              sram_oe_n
);
    logic [NSTRB-1:0] strb_s;
    logic [NSTRB-1:0] fire;
    logic [NSTRB-1:0] rise;
    logic [HALF_W-1:0] row_q, col_q;
    logic [DATA_W-1:0] wd_q;
    logic col_ok_q, wd_ok_q, rd_drive_q;
    logic wr_go, rd_go;
    wmode_e wmode;

    assign wmode = wmode_e'(mode_split);

    vsb_sync #(.W(NSTRB), .RST_VAL(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({rw_n, cas_n, ras_n}),
        .q_sync (strb_s)
    );

    for (genvar s = 0; s < NSTRB; s++) begin : g_tmr
        vsb_strobe_timer #(.DLY(CAPT_DLY)) u_tmr (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl_n(strb_s[s]),
            .fire (fire[s]),
            .rise (rise[s])
        );
    end

    // Address halves: latch the upper seven bus bits at each delayed capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (fire[S_RAS]) row_q <= ad[DATA_W-1:1];
            if (fire[S_CAS]) col_q <= ad[DATA_W-1:1];
        end
    end

    // Write byte: source chosen by bus variant, captured after R/W falls.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wd_q <= '0;
        else if (fire[S_RW])
            wd_q <= (wmode == WMODE_SPLIT) ? rd_i : ad;
    end

    // Validity flags: set on capture, cleared when the owning strobe ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_ok_q <= 1'b0;
            wd_ok_q  <= 1'b0;
        end else begin
            if (rise[S_CAS])      col_ok_q <= 1'b0;
            else if (fire[S_CAS]) col_ok_q <= 1'b1;
            if (rise[S_CAS] || rise[S_RW]) wd_ok_q <= 1'b0;
            else if (fire[S_RW])           wd_ok_q <= 1'b1;
        end
    end

    assign wr_go = col_ok_q & wd_ok_q & ~strb_s[S_RW] & ~strb_s[S_CAS];
    assign rd_go = col_ok_q & strb_s[S_RW] & ~strb_s[S_CAS];

    // SRAM side: registered strobes, address and write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_we_n  <= 1'b1;
            sram_oe_n  <= 1'b1;
            rd_drive_q <= 1'b0;
            sram_addr  <= '0;
            sram_wdata <= '0;
        end else begin
            sram_we_n  <= ~wr_go;
            sram_oe_n  <= ~rd_go;
            rd_drive_q <= rd_go;
            sram_addr  <= {{FILL_W{1'b0}}, row_q, col_q};
            sram_wdata <= wd_q;
        end
    end

    // Read path keeps bit positions; release the bus at once on R/W low.
    assign rd_o  = sram_rdata;
    assign rd_oe = rd_drive_q & rw_n;
endmodule

// File: rtl/vsb_checks.sv
// Property checker for vram_sram_bridge, attached by bind.
// Assumes the top's port names and widths at their default values.
module vsb_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        rw_n,
    input logic        rd_oe,
    input logic [14:0] sram_addr,
    input logic [7:0]  sram_wdata,
    input logic        sram_we_n,
    input logic        sram_oe_n
);
    p_a14_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sram_addr[14] == 1'b0);

    p_rd_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_n |-> !rd_oe);

    p_we_oe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    p_wr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_wdata)));

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (sram_we_n && sram_oe_n && !rd_oe));
endmodule

bind vram_sram_bridge vsb_checks u_vsb_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .rw_n      (rw_n),
    .rd_oe     (rd_oe),
    .sram_addr (sram_addr),
    .sram_wdata(sram_wdata),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n)
);

// File: tb/vram_sram_bridge_tb.sv
`timescale 1ns/1ps
// Self-checking bench: models both controller variants with late bus data,
// a behavioural SRAM, and a reference memory of written bytes.
module vram_sram_bridge_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_split = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, rw_n = 1'b1;
    logic [7:0] ad = 8'h00;
    logic [7:0] rd_val = 8'h00;
    logic rd_drv = 1'b0;
    logic [7:0] rd_i, rd_o, sram_wdata, sram_rdata;
    logic rd_oe, sram_we_n, sram_oe_n;
    logic [14:0] sram_addr;

    int checks = 0, errors = 0;
    int we_cnt = 0, clash_cnt = 0;
    logic [14:0] we_addr;
    logic [7:0]  we_data;
    logic [7:0] mem [int];
    logic [7:0] refm [int];

    always #2.5 clk = ~clk;
    assign rd_i = rd_drv ? rd_val : 8'h00;

    vram_sram_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .mode_split(mode_split),
        .ras_n(ras_n), .cas_n(cas_n), .rw_n(rw_n), .ad(ad), .rd_i(rd_i),
        .rd_o(rd_o), .rd_oe(rd_oe), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    // SRAM model: read data settles shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (!sram_oe_n && mem.exists(int'(sram_addr)))
            sram_rdata = mem[int'(sram_addr)];
        else
            sram_rdata = 8'h00;
    end

    // Bus monitor away from the active edge: writes, overlaps.
    always @(negedge clk) begin
        if (rst_n && !sram_we_n) begin
            we_cnt++;
            we_addr = sram_addr;
            we_data = sram_wdata;
            mem[int'(sram_addr)] = sram_wdata;
        end
        if (rst_n && rd_oe && (rd_drv || !rw_n)) clash_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One controller cycle; bus data lags each strobe by two clocks.
    task automatic bus_cycle(input bit wr, input logic [13:0] a, input logic [7:0] wd,
                             output logic [7:0] rv, output bit oe_seen, output int wes);
        we_cnt = 0;
        @(negedge clk); ad = {a[13:7], 1'b1}; ras_n = 1'b0;
        repeat (4) @(negedge clk);
        cas_n = 1'b0;
        if (wr && mode_split) begin rw_n = 1'b0; rd_drv = 1'b1; rd_val = wd; end
        repeat (2) @(negedge clk);
        ad = {a[6:0], 1'b0};
        repeat (6) @(negedge clk);
        rv = rd_o; oe_seen = rd_oe;
        if (wr && !mode_split) begin
            repeat (2) @(negedge clk); rw_n = 1'b0;
            repeat (2) @(negedge clk); ad = wd;
        end
        repeat (20) @(negedge clk);
        if (!wr) begin
            // R6: data still presented just before the column strobe ends
            chk(rd_oe && rd_o == rv, "R6 hold", {rd_oe, rd_o}, {1'b1, rv});
        end
        cas_n = 1'b1; rw_n = 1'b1; rd_drv = 1'b0;
        @(negedge clk); ras_n = 1'b1; ad = 8'h5A;
        repeat (8) @(negedge clk);
        wes = we_cnt;
    endtask

    task automatic do_write(input logic [13:0] a, input logic [7:0] d);
        logic [7:0] rv; bit oe; int wes;
        bus_cycle(1'b1, a, d, rv, oe, wes);
        refm[int'(a)] = d;
        // R4/R5: write pulse carries rebuilt address (R2) and the byte
        chk(wes > 0, mode_split ? "R5 we pulse" : "R4 we pulse", wes, 1);
        chk(we_addr == {1'b0, a}, "R2 write address", we_addr, {1'b0, a});
        chk(we_data == d, mode_split ? "R5 write byte" : "R4 write byte", we_data, d);
    endtask

    task automatic do_read(input logic [13:0] a);
        logic [7:0] rv; bit oe; int wes;
        bus_cycle(1'b0, a, 8'h00, rv, oe, wes);
        // R6/R7: byte back on same bit positions within 8 clocks of CAS
        chk(oe && rv == refm[int'(a)], "R6 R7 read data", {oe, rv}, {1'b1, refm[int'(a)]});
        chk(wes == 0, "R10 no write on read", wes, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: idle outputs during reset
        chk(sram_we_n && sram_oe_n && !rd_oe, "R1 in reset", {sram_we_n, sram_oe_n, rd_oe}, 3'b110);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(sram_we_n && sram_oe_n && !rd_oe, "R1 after reset", {sram_we_n, sram_oe_n, rd_oe}, 3'b110);

        for (int m = 0; m < 2; m++) begin
            mode_split = m[0];
            // Walking-one addresses plus both ends of the space (R2, R3)
            for (int k = 0; k < 14; k++)
                do_write(14'(1 << k), 8'((k * 37 + 11) ^ (m * 8'hA5)));
            do_write(14'h0000, 8'(8'h81 ^ m));
            do_write(14'h3FFF, 8'(8'h7E ^ m));
            // Single-bit data bytes to pin each bit position (R7)
            for (int b = 0; b < 8; b++)
                do_write(14'(14'h1230 + b), 8'(1 << b));
            for (int k = 0; k < 14; k++) do_read(14'(1 << k));
            do_read(14'h0000);
            do_read(14'h3FFF);
            for (int b = 0; b < 8; b++) do_read(14'(14'h1230 + b));
        end
        // R3: reads in the multiplexed mode of data written in split mode
        mode_split = 1'b0;
        do_read(14'h2000);
        do_read(14'h0040);

        // R8: no read-data drive while R/W low or controller driving
        chk(clash_cnt == 0, "R8 bus release", clash_cnt, 0);
        // R2: top address bit stays low
        chk(sram_addr[14] == 1'b0, "R2 A14 low", sram_addr[14], 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule